// File: doc/BRIEF.md
# Test-Environment I/O Control Peripheral

This block sits on the 8-bit I/O bus of a small processor that runs inside a simulation environment. It claims one aligned window of 32 port addresses and gives the program running on the processor a set of verification services. The program can end the run with a pass or fail verdict and switch waveform capture on or off. It can send a text line one character at a time. It can arm a watchdog that flags a hung program and schedule an interrupt a set number of clocks in the future. It can also keep a running byte checksum and read a counter that advances each time it is read.

All state changes take effect at the clock edge that samples the strobe. Read data is combinational from the address and the read strobe. The surrounding environment watches `run_pass`, `run_fail`, `dump_on`, `timeout_err` and the line outputs, and feeds `int_n` back to the processor's interrupt input.

Top module: `envctl_io`

## Requirements
- R1: Only addresses 0x80 to 0x9F are decoded. A write anywhere else changes no state. A read of any address that is outside the window, unmapped or write-only returns 0xFF, and `io_rdata` is 0xFF while `io_rd` is low.
- R2: Reset clears `run_pass`, `run_fail` and `dump_on`. On the edge after a write to 0x80, data 0x01 sets `run_pass` and 0x02 sets `run_fail`; both flags then stay set until reset. Data 0x03 sets `dump_on`, 0x04 clears it, and any other value is ignored.
- R3: A byte other than 0x0A written to 0x81 is stored at index `line_len`, which is bits [8i+7:8i] of `line_data` for index i. `line_len` then grows by one.
- R4: A write of 0x0A to 0x81 is not stored. On the next edge it raises `line_ready` for exactly one cycle, with `line_len` and `line_data` still holding the line. On the edge after that, `line_len` returns to 0, or to 1 if a character is written in that cycle.
- R5: When the buffer already holds LINE_MAX (80) characters, further characters are dropped and `line_len` never exceeds LINE_MAX.
- R6: At 0x82, bit 0 enables the watchdog counter and bit 1 clears both the count and `timeout_err`. After reset the counter is enabled, starts from 0 and advances once per clock while enabled.
- R7: 0x83 holds the low byte and 0x84 the high byte of the watchdog limit, which resets to 0xFFFF. `timeout_err` is set on the edge where the enabled count equals the limit. It stays set until a write to 0x82 with bit 1 high.
- R8: Writing N (non-zero) to 0x90 drives `int_n` high and then low on the N-th edge after the write edge. `int_n` stays low until 0x90 is written again. Writing 0 stops any countdown and releases `int_n`.
- R9: 0x91 reads back the checksum byte, and a write to 0x91 replaces it. The checksum resets to 0.
- R10: Each write to 0x92 adds its byte to the checksum modulo 256. Reads of 0x92 return 0xFF.
- R11: A read of 0x93 returns the sequence value, which resets to 0. The value advances by one on the edge where a read strobe addressed to 0x93 ends, whatever the strobe's length. A write to 0x93 loads a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one write per cycle it is high |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| int_n | output | 1 | Active-low interrupt from the countdown |
| timeout_err | output | 1 | Watchdog limit reached |
| run_pass | output | 1 | Run ended with pass verdict |
| run_fail | output | 1 | Run ended with fail verdict |
| dump_on | output | 1 | Waveform capture requested |
| line_ready | output | 1 | One-cycle pulse: a complete line is held |
| line_len | output | 7 | Number of buffered characters |
| line_data | output | 640 | Buffered characters, index i in bits [8i+7:8i] |

## Verification
Every registered result is due on the first rising edge after the write cycle. The exceptions are `int_n`, which falls N edges after the write that loads N, and `timeout_err`, which follows the count reaching the limit. `io_rdata` is due in the same cycle the read strobe is high, and the sequence value changes only on the edge that ends the strobe. The bench drives inputs at the falling edge and keeps a behavioural model that advances on each rising edge. It compares every output against that model at the following falling edge, so every result is checked in exactly the cycle it is due, never a cycle early or late.

// File: rtl/envctl_pkg.sv
package envctl_pkg;
   localparam int OFS_W = 5;
   localparam logic [OFS_W-1:0] OFS_CMD   = 5'h00;
   localparam logic [OFS_W-1:0] OFS_TEXT  = 5'h01;
   localparam logic [OFS_W-1:0] OFS_WDCTL = 5'h02;
   localparam logic [OFS_W-1:0] OFS_LIMLO = 5'h03;
   localparam logic [OFS_W-1:0] OFS_LIMHI = 5'h04;
   localparam logic [OFS_W-1:0] OFS_DELAY = 5'h10;
   localparam logic [OFS_W-1:0] OFS_SUM   = 5'h11;
   localparam logic [OFS_W-1:0] OFS_ADD   = 5'h12;
   localparam logic [OFS_W-1:0] OFS_SEQ   = 5'h13;

   typedef enum logic [7:0] {
      CMD_PASS     = 8'h01,
      CMD_FAIL     = 8'h02,
      CMD_DUMP_ON  = 8'h03,
      CMD_DUMP_OFF = 8'h04
   } env_cmd_e;

   localparam logic [7:0] CHAR_NL = 8'h0A;
endpackage

// File: rtl/envctl_linebuf.sv
module envctl_linebuf #(
   parameter int LINE_MAX = 80,
   parameter int LEN_W    = $clog2(LINE_MAX + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic [7:0]              din,
   output logic                    line_ready,
   output logic [LEN_W-1:0]        line_len,
   output logic [LINE_MAX*8-1:0]   line_data
);
   import envctl_pkg::*;

   if (LINE_MAX < 1 || LINE_MAX > 255) begin : g_bad_depth
      $error("envctl_linebuf: LINE_MAX out of range");
   end
   if ((1 << LEN_W) <= LINE_MAX) begin : g_bad_lenw
      $error("envctl_linebuf: LEN_W too narrow");
   end

   logic [LEN_W-1:0] base_len;
   logic             is_nl;
   logic             room;
   logic             store;

   assign base_len = line_ready ? '0 : line_len;
   assign is_nl    = (din == CHAR_NL);
   assign room     = (base_len < LEN_W'(LINE_MAX));
   assign store    = push && !is_nl && room;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_ready <= 1'b0;
         line_len   <= '0;
      end else begin
         line_ready <= push && is_nl;
         line_len   <= store ? base_len + 1'b1 : base_len;
      end
   end

   for (genvar i = 0; i < LINE_MAX; i++) begin : g_slot
      logic [7:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q <= '0;
         else if (store && base_len == LEN_W'(i))
            slot_q <= din;
      end
      assign line_data[8*i +: 8] = slot_q;
   end

   // R4
   ready_then_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_ready |=> (line_len <= LEN_W'(1)));
   // R5
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_len <= LEN_W'(LINE_MAX));
endmodule

// File: rtl/envctl_watchdog.sv
module envctl_watchdog #(
   parameter int TO_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic       lo_wr,
   input  logic       hi_wr,
   input  logic [7:0] wdata,
   output logic       timeout_err
);
   if (TO_W <= 8 || TO_W > 16) begin : g_bad_width
      $error("envctl_watchdog: TO_W must be 9..16");
   end

   logic            run_en;
   logic [TO_W-1:0] count_q;
   logic [TO_W-1:0] limit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_en      <= 1'b1;
         count_q     <= '0;
         limit_q     <= '1;
         timeout_err <= 1'b0;
      end else begin
         if (lo_wr) limit_q[7:0]      <= wdata;
         if (hi_wr) limit_q[TO_W-1:8] <= wdata[TO_W-9:0];
         if (ctl_wr) begin
            run_en <= wdata[0];
            if (wdata[1]) begin
               count_q     <= '0;
               timeout_err <= 1'b0;
            end
         end else if (run_en) begin
            if (count_q == limit_q) timeout_err <= 1'b1;
            else                    count_q     <= count_q + 1'b1;
         end
      end
   end

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_err && !ctl_wr) |=> timeout_err);
   // R6
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[1]) |=> !timeout_err);
endmodule

// File: rtl/envctl_countdown.sv
module envctl_countdown #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             int_n
);
   if (CNT_W < 1) begin : g_bad_width
      $error("envctl_countdown: CNT_W must be positive");
   end

   logic             active_q;
   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         remain_q <= '0;
         int_n    <= 1'b1;
      end else if (load) begin
         int_n    <= 1'b1;
         active_q <= (load_val != '0);
         remain_q <= load_val;
      end else if (active_q) begin
         if (remain_q == CNT_W'(1)) begin
            active_q <= 1'b0;
            int_n    <= 1'b0;
         end else begin
            remain_q <= remain_q - 1'b1;
         end
      end
   end

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_n && !load) |=> !int_n);
   // R8
   irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> int_n);
endmodule

// File: rtl/envctl_io.sv
module envctl_io #(
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  BASE     = 8'h80,
   parameter int          LINE_MAX = 80,
   parameter int          TO_W     = 16,
   parameter int          LEN_W    = $clog2(LINE_MAX + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            io_addr,
   input  logic [DATA_W-1:0]     io_wdata,
   input  logic                  io_wr,
   input  logic                  io_rd,
   output logic [DATA_W-1:0]     io_rdata,
   output logic                  int_n,
   output logic                  timeout_err,
   output logic                  run_pass,
   output logic                  run_fail,
   output logic                  dump_on,
   output logic                  line_ready,
   output logic [LEN_W-1:0]      line_len,
   output logic [LINE_MAX*8-1:0] line_data
);
   import envctl_pkg::*;

   if (DATA_W != 8) begin : g_bad_data
      $error("envctl_io: DATA_W must be 8");
   end
   if (BASE[OFS_W-1:0] != '0) begin : g_bad_base
      $error("envctl_io: BASE must be aligned to the window");
   end

   logic             hit;
   logic [OFS_W-1:0] ofs;
   logic             wr_hit;
   logic [7:0]       csum_q;
   logic [7:0]       seq_q;
   logic             seq_rd_q;

   assign hit    = (io_addr[7:OFS_W] == BASE[7:OFS_W]);
   assign ofs    = io_addr[OFS_W-1:0];
   assign wr_hit = io_wr && hit;

   envctl_linebuf #(.LINE_MAX(LINE_MAX), .LEN_W(LEN_W)) u_line (
      .clk(clk), .rst_n(rst_n),
      .push(wr_hit && ofs == OFS_TEXT), .din(io_wdata),
      .line_ready(line_ready), .line_len(line_len), .line_data(line_data)
   );

   envctl_watchdog #(.TO_W(TO_W)) u_wdog (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(wr_hit && ofs == OFS_WDCTL),
      .lo_wr(wr_hit && ofs == OFS_LIMLO),
      .hi_wr(wr_hit && ofs == OFS_LIMHI),
      .wdata(io_wdata), .timeout_err(timeout_err)
   );

   envctl_countdown #(.CNT_W(DATA_W)) u_delay (
      .clk(clk), .rst_n(rst_n),
      .load(wr_hit && ofs == OFS_DELAY), .load_val(io_wdata),
      .int_n(int_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_pass <= 1'b0;
         run_fail <= 1'b0;
         dump_on  <= 1'b0;
      end else if (wr_hit && ofs == OFS_CMD) begin
         case (io_wdata)
            CMD_PASS:     run_pass <= 1'b1;
            CMD_FAIL:     run_fail <= 1'b1;
            CMD_DUMP_ON:  dump_on  <= 1'b1;
            CMD_DUMP_OFF: dump_on  <= 1'b0;
            default:      ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csum_q   <= '0;
         seq_q    <= '0;
         seq_rd_q <= 1'b0;
      end else begin
         if (wr_hit && ofs == OFS_SUM)      csum_q <= io_wdata;
         else if (wr_hit && ofs == OFS_ADD) csum_q <= csum_q + io_wdata;
         if (wr_hit && ofs == OFS_SEQ)      seq_q  <= io_wdata;
         else if (seq_rd_q && !io_rd)       seq_q  <= seq_q + 1'b1;
         seq_rd_q <= io_rd && hit && ofs == OFS_SEQ;
      end
   end

   always_comb begin
      io_rdata = '1;
      if (io_rd && hit) begin
         case (ofs)
            OFS_SUM: io_rdata = csum_q;
            OFS_SEQ: io_rdata = seq_q;
            default: io_rdata = '1;
         endcase
      end
   end

   // R2
   pass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_pass |=> run_pass);
   // R2
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_fail |=> run_fail);
   // R1
   outside_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !hit) |-> (io_rdata == 8'hFF));
   // R10
   add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && ofs == OFS_ADD) |=> (csum_q == $past(csum_q + io_wdata)));
   // R11
   seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !(wr_hit && ofs == OFS_SEQ)) |=> $stable(seq_q));
endmodule

// File: tb/envctl_io_test.sv
module envctl_io_test;
   localparam int LMAX = 80;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   io_addr = 8'h00;
   logic [7:0]   io_wdata = 8'h00;
   logic         io_wr = 1'b0;
   logic         io_rd = 1'b0;
   logic [7:0]   io_rdata;
   logic         int_n, timeout_err, run_pass, run_fail, dump_on, line_ready;
   logic [6:0]   line_len;
   logic [LMAX*8-1:0] line_data;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   envctl_io uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .int_n(int_n),
      .timeout_err(timeout_err), .run_pass(run_pass), .run_fail(run_fail),
      .dump_on(dump_on), .line_ready(line_ready), .line_len(line_len),
      .line_data(line_data)
   );

   // behavioural reference model
   int m_pass = 0, m_fail = 0, m_dump = 0, m_ready = 0;
   logic [7:0] m_line[$];
   int m_wen = 1, m_wcnt = 0, m_wlim = 'hFFFF, m_err = 0;
   int m_cact = 0, m_ccnt = 0, m_intn = 1;
   int m_sum = 0, m_seq = 0, m_seqrd = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pass = 0; m_fail = 0; m_dump = 0; m_ready = 0; m_line.delete();
         m_wen = 1; m_wcnt = 0; m_wlim = 'hFFFF; m_err = 0;
         m_cact = 0; m_ccnt = 0; m_intn = 1;
         m_sum = 0; m_seq = 0; m_seqrd = 0;
      end else begin
         automatic bit w = io_wr && io_addr >= 8'h80 && io_addr <= 8'h9F;
         automatic int d = io_wdata;
         if (m_ready != 0) m_line.delete();
         m_ready = 0;
         if (w && io_addr == 8'h80) begin
            if (d == 1) m_pass = 1;
            if (d == 2) m_fail = 1;
            if (d == 3) m_dump = 1;
            if (d == 4) m_dump = 0;
         end
         if (w && io_addr == 8'h81) begin
            if (d == 10) m_ready = 1;
            else if (m_line.size() < LMAX) m_line.push_back(io_wdata);
         end
         if (w && io_addr == 8'h83) m_wlim = (m_wlim & 'hFF00) | d;
         if (w && io_addr == 8'h84) m_wlim = (m_wlim & 'h00FF) | (d << 8);
         if (w && io_addr == 8'h82) begin
            m_wen = d & 1;
            if ((d & 2) != 0) begin m_wcnt = 0; m_err = 0; end
         end else if (m_wen != 0) begin
            if (m_wcnt == m_wlim) m_err = 1;
            else m_wcnt = (m_wcnt + 1) & 'hFFFF;
         end
         if (w && io_addr == 8'h90) begin
            m_intn = 1; m_cact = (d != 0); m_ccnt = d;
         end else if (m_cact != 0) begin
            if (m_ccnt == 1) begin m_cact = 0; m_intn = 0; end
            else m_ccnt = m_ccnt - 1;
         end
         if (w && io_addr == 8'h91) m_sum = d;
         else if (w && io_addr == 8'h92) m_sum = (m_sum + d) & 'hFF;
         if (w && io_addr == 8'h93) m_seq = d;
         else if (m_seqrd != 0 && !io_rd) m_seq = (m_seq + 1) & 'hFF;
         m_seqrd = io_rd && io_addr == 8'h93;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_rdata();
      if (!io_rd) return 'hFF;
      if (io_addr == 8'h91) return m_sum;
      if (io_addr == 8'h93) return m_seq;
      return 'hFF;
   endfunction

   task automatic compare_all();
      chk("R2 run_pass", run_pass, m_pass);
      chk("R2 run_fail", run_fail, m_fail);
      chk("R2 dump_on", dump_on, m_dump);
      chk("R4 line_ready", line_ready, m_ready);
      chk("R3/R5 line_len", line_len, m_line.size());
      for (int i = 0; i < m_line.size(); i++)
         chk("R3 line_data", line_data[8*i +: 8], m_line[i]);
      chk("R6/R7 timeout_err", timeout_err, m_err);
      chk("R8 int_n", int_n, m_intn);
      chk("R1/R9/R10/R11 io_rdata", io_rdata, exp_rdata());
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      tick();
      io_wr = 1'b0;
      tick();
   endtask

   task automatic rd(logic [7:0] a, int len);
      io_addr = a; io_rd = 1'b1;
      for (int i = 0; i < len; i++) tick();
      io_rd = 1'b0;
      tick();
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      tick();
      // reset state (R2, R6, R8, R9, R11)
      chk("R2 reset pass", run_pass, 0);
      chk("R8 reset int_n", int_n, 1);
      rd(8'h91, 1);
      rd(8'h93, 1);

      // R1: outside-window writes and reads
      wr(8'h7F, 8'h01);
      wr(8'hA0, 8'h01);
      wr(8'hB1, 8'h55);
      rd(8'h50, 2);
      rd(8'hB3, 1);
      rd(8'h92, 1);
      rd(8'h85, 1);
      chk("R1 pass untouched", run_pass, 0);

      // R2: commands
      wr(8'h80, 8'h05);
      wr(8'h80, 8'h03);
      chk("R2 dump set", dump_on, 1);
      wr(8'h80, 8'h04);
      wr(8'h80, 8'h01);
      chk("R2 pass set", run_pass, 1);
      wr(8'h80, 8'h02);
      idle(3);

      // R3, R4: short line
      wr(8'h81, "H");
      wr(8'h81, "i");
      io_addr = 8'h81; io_wdata = 8'h0A; io_wr = 1'b1;
      tick();
      io_wr = 1'b0;
      chk("R4 pulse with line", line_ready, 1);
      chk("R4 length kept", line_len, 2);
      tick();
      chk("R4 cleared", line_len, 0);
      // char right after newline pulse
      wr(8'h81, 8'h0A);
      io_addr = 8'h81; io_wdata = "x"; io_wr = 1'b1;
      tick();
      io_wr = 1'b0;
      tick();
      // R5: overflow
      for (int i = 0; i < LMAX + 3; i++) wr(8'h81, 8'h20 + i[7:0]);
      chk("R5 saturated", line_len, LMAX);
      wr(8'h81, 8'h0A);
      idle(2);

      // R6, R7: watchdog
      wr(8'h82, 8'h03);
      wr(8'h83, 8'h14);
      wr(8'h84, 8'h00);
      idle(30);
      chk("R7 timeout raised", timeout_err, 1);
      wr(8'h82, 8'h02);
      chk("R6 cleared and stopped", timeout_err, 0);
      idle(40);
      wr(8'h82, 8'h01);
      idle(25);

      // R8: countdown
      wr(8'h90, 8'h05);
      idle(6);
      chk("R8 asserted", int_n, 0);
      idle(4);
      wr(8'h90, 8'h00);
      chk("R8 released", int_n, 1);
      wr(8'h90, 8'h03);
      wr(8'h90, 8'h00);
      idle(6);
      wr(8'h90, 8'h01);
      idle(2);

      // R9, R10: checksum
      wr(8'h91, 8'hF0);
      rd(8'h91, 1);
      wr(8'h92, 8'h20);
      rd(8'h91, 1);
      wr(8'h92, 8'hFF);
      wr(8'h92, 8'h01);
      rd(8'h91, 2);

      // R11: sequence register
      wr(8'h93, 8'hFE);
      rd(8'h93, 1);
      rd(8'h93, 4);
      rd(8'h93, 1);
      chk("R11 wrapped", m_seq, 1);
      rd(8'h93, 1);
      idle(3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule